// File: doc/BRIEF.md
# Flash Command Decoder

This block is a synthesizable behavioural model of the command decoder found in a NOR-style flash memory with a 16-bit data bus. It watches bus write cycles, qualified by active-low chip enable and write enable. A write cycle is taken as finished when either enable rises. The low byte of the written data is decoded as a command. Single-cycle commands select the read mode: array, identifier or status. Another single-cycle command clears the sticky error flags. Two-cycle sequences start a block erase or a word write. Any write that overlaps an active output enable is rejected and flagged on a dedicated output.

Erase and word write run for a fixed number of clock cycles, counted by a busy timer. A running operation can be paused with a suspend command, and the timer keeps the remaining count until a resume command restarts it. The storage is a small register file that powers up erased (all ones). Driving the reset/power-down pin low aborts any operation, clears the status flags, disables the data outputs and returns the decoder to array mode.

States are: READY (idle), ERASE_SETUP and WRITE_SETUP (first cycle seen), ERASE_BUSY and WRITE_BUSY (timer running), and ERASE_SUSP and WRITE_SUSP (timer frozen). The transitions are:
- READY to ERASE_SETUP on 20h.
- READY to WRITE_SETUP on 40h or 10h.
- ERASE_SETUP to ERASE_BUSY on D0h within the same block.
- ERASE_SETUP back to READY with errors on anything else.
- WRITE_SETUP to WRITE_BUSY on any write.
- BUSY to READY when the timer expires.
- BUSY to SUSP on B0h.
- SUSP to BUSY on D0h.
- Any state to READY while the power-down pin is low.

Top module: `flash_cmd_if`

## Requirements
- R1: Writing FFh selects array mode; array reads return the stored word at the read address, and every word reads FFFFh after system reset.
- R2: Writing 90h selects identifier mode; a read with address bit 0 clear returns MFR_CODE, with bit 0 set returns DEV_CODE, and the mode holds until another mode command.
- R3: Writing 70h selects status mode; a status read returns a word with bit 7 = ready, bit 6 = suspended, bit 5 = erase/sequence error, bit 4 = write error, all other bits 0.
- R4: Writing 50h clears status bits 5 and 4 and leaves the read mode unchanged.
- R5: 20h followed by D0h to an address in the same block (block = top BLK_W address bits) makes the device busy (bit 7 = 0) for exactly ERASE_CYCLES clocks after the confirm, in status mode, and then sets every word of that block to FFFFh, leaving other blocks untouched.
- R6: If the write after 20h is not D0h, or goes to another block, nothing is erased, bits 5 and 4 are set, the device is ready and in status mode.
- R7: 40h or 10h followed by a second write makes the device busy for WRITE_CYCLES clocks, then stores the second write's data at its address.
- R8: Address and data are taken from the last clock in which chip enable and write enable were both low; the command takes effect on the clock in which either of them is first seen high.
- R9: B0h during an erase or word write suspends it: status reads ready=1 and suspended=1, the timer stops, and FFh/90h/70h may be used. D0h resumes it, and the operation finishes with its remaining count. B0h and D0h are ignored when no operation is running.
- R10: A write cycle during which output enable is also low is discarded, oe_we_clash is high while the three enables are low together, and dout_en stays low.
- R11: While rp_n is low, dout_en is 0 and writes are ignored. A running operation is aborted without changing storage, the status flags clear, and array mode is selected.
- R12: dout_en is 1 only while ce_n and oe_n are low, we_n is high and rp_n is high, and dout is 0 otherwise.
- R13: Command codes other than those listed are ignored in READY and leave the read mode as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock; bus pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous system reset, active low (power-on) |
| rp_n | input | 1 | Reset/power-down pin, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data from the bus |
| dout | output | DATA_W | Read data toward the bus |
| dout_en | output | 1 | Read data drive enable |
| oe_we_clash | output | 1 | Output and write enables low together while selected |

## Verification
A wrong decoder state shows up in the very next read: the read multiplexer picks its source from the registered mode, so an array read returning an identifier code or a status word exposes it half a clock after the command edge. Timer errors show as the ready bit changing one clock early or late relative to the confirm. This is why the bench samples the status word on the last expected busy clock and on the first ready clock. A lost suspend or a wrong block decode surfaces only when the array is read back after completion, so every operation is followed by array reads that are compared with a reference copy of the storage.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_READY,
        ST_ERASE_SETUP,
        ST_WRITE_SETUP,
        ST_ERASE_BUSY,
        ST_WRITE_BUSY,
        ST_ERASE_SUSP,
        ST_WRITE_SUSP
    } fsm_state_t;

    typedef enum logic [1:0] {
        RM_ARRAY,
        RM_IDENT,
        RM_STATUS
    } read_mode_t;

    typedef struct packed {
        logic ready;
        logic suspended;
        logic erase_err;
        logic write_err;
    } status_t;

    localparam logic [7:0] OP_MODE_ARRAY  = 8'hFF;
    localparam logic [7:0] OP_MODE_IDENT  = 8'h90;
    localparam logic [7:0] OP_MODE_STATUS = 8'h70;
    localparam logic [7:0] OP_CLEAR_ERR   = 8'h50;
    localparam logic [7:0] OP_ERASE_SETUP = 8'h20;
    localparam logic [7:0] OP_PROG_SETUP  = 8'h40;
    localparam logic [7:0] OP_PROG_ALT    = 8'h10;
    localparam logic [7:0] OP_CONFIRM     = 8'hD0;
    localparam logic [7:0] OP_SUSPEND     = 8'hB0;

endpackage

// File: rtl/bus_write_capture.sv
module bus_write_capture #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rp_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              strobe,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data,
    output logic              clash
);
    logic active;
    logic active_q;
    logic poisoned;

    assign active = !ce_n && !we_n && rp_n;
    assign clash  = !ce_n && !we_n && !oe_n && rp_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            poisoned <= 1'b0;
            cap_addr <= '0;
            cap_data <= '0;
        end else begin
            active_q <= active;
            if (active) begin
                cap_addr <= addr;
                cap_data <= din;
                poisoned <= (active_q ? poisoned : 1'b0) | !oe_n;
            end
        end
    end

    // a cycle ends when either enable is first seen high
    assign strobe = active_q && !active && rp_n && !poisoned;

    // R10
    clash_blocks_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clash |=> !strobe);

endmodule

// File: rtl/busy_timer.sv
module busy_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             done,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (run && count != '0) begin
            count <= count - 1'b1;
        end
    end

    assign done = run && (count == CNT_W'(1));

    // R5
    timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr) |=> (count == $past(load_val)));

endmodule

// File: rtl/cmd_fsm.sv
module cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W       = 5,
    parameter int DATA_W       = 16,
    parameter int BLK_W        = 2,
    parameter int CNT_W        = 6,
    parameter int ERASE_CYCLES = 40,
    parameter int WRITE_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rp_n,
    input  logic              strobe,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              tmr_done,
    output fsm_state_t        state,
    output read_mode_t        rmode,
    output status_t           status,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_load_val,
    output logic              tmr_run,
    output logic              tmr_clr,
    output logic              commit_erase,
    output logic              commit_write,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data
);
    localparam int BLK_LSB = ADDR_W - BLK_W;

    fsm_state_t state_d;
    read_mode_t rmode_d;
    logic       erase_err, erase_err_d;
    logic       write_err, write_err_d;
    logic       latch_op;
    logic [7:0] opcode;
    logic       same_block;

    assign opcode     = cap_data[7:0];
    assign same_block = (cap_addr[ADDR_W-1:BLK_LSB] == op_addr[ADDR_W-1:BLK_LSB]);

    // next state and transitions
    always_comb begin
        state_d      = state;
        rmode_d      = rmode;
        erase_err_d  = erase_err;
        write_err_d  = write_err;
        latch_op     = 1'b0;
        tmr_load     = 1'b0;
        tmr_load_val = '0;
        unique case (state)
            ST_READY: begin
                if (strobe) begin
                    case (opcode)
                        OP_MODE_ARRAY:  rmode_d = RM_ARRAY;
                        OP_MODE_IDENT:  rmode_d = RM_IDENT;
                        OP_MODE_STATUS: rmode_d = RM_STATUS;
                        OP_CLEAR_ERR: begin
                            erase_err_d = 1'b0;
                            write_err_d = 1'b0;
                        end
                        OP_ERASE_SETUP: begin
                            state_d  = ST_ERASE_SETUP;
                            rmode_d  = RM_STATUS;
                            latch_op = 1'b1;
                        end
                        OP_PROG_SETUP, OP_PROG_ALT: begin
                            state_d = ST_WRITE_SETUP;
                            rmode_d = RM_STATUS;
                        end
                        default: ;
                    endcase
                end
            end
            ST_ERASE_SETUP: begin
                if (strobe) begin
                    rmode_d = RM_STATUS;
                    if (opcode == OP_CONFIRM && same_block) begin
                        state_d      = ST_ERASE_BUSY;
                        tmr_load     = 1'b1;
                        tmr_load_val = CNT_W'(ERASE_CYCLES);
                    end else begin
                        state_d     = ST_READY;
                        erase_err_d = 1'b1;
                        write_err_d = 1'b1;
                    end
                end
            end
            ST_WRITE_SETUP: begin
                if (strobe) begin
                    state_d      = ST_WRITE_BUSY;
                    latch_op     = 1'b1;
                    tmr_load     = 1'b1;
                    tmr_load_val = CNT_W'(WRITE_CYCLES);
                end
            end
            ST_ERASE_BUSY, ST_WRITE_BUSY: begin
                if (tmr_done) begin
                    state_d = ST_READY;
                end else if (strobe) begin
                    if (opcode == OP_SUSPEND) begin
                        state_d = (state == ST_ERASE_BUSY) ? ST_ERASE_SUSP : ST_WRITE_SUSP;
                        rmode_d = RM_STATUS;
                    end else if (opcode == OP_MODE_STATUS) begin
                        rmode_d = RM_STATUS;
                    end
                end
            end
            ST_ERASE_SUSP, ST_WRITE_SUSP: begin
                if (strobe) begin
                    case (opcode)
                        OP_CONFIRM: begin
                            state_d = (state == ST_ERASE_SUSP) ? ST_ERASE_BUSY : ST_WRITE_BUSY;
                            rmode_d = RM_STATUS;
                        end
                        OP_MODE_ARRAY:  rmode_d = RM_ARRAY;
                        OP_MODE_IDENT:  rmode_d = RM_IDENT;
                        OP_MODE_STATUS: rmode_d = RM_STATUS;
                        default: ;
                    endcase
                end
            end
            default: state_d = ST_READY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_READY;
            rmode     <= RM_ARRAY;
            erase_err <= 1'b0;
            write_err <= 1'b0;
            op_addr   <= '0;
            op_data   <= '0;
        end else if (!rp_n) begin
            state     <= ST_READY;
            rmode     <= RM_ARRAY;
            erase_err <= 1'b0;
            write_err <= 1'b0;
        end else begin
            state     <= state_d;
            rmode     <= rmode_d;
            erase_err <= erase_err_d;
            write_err <= write_err_d;
            if (latch_op) begin
                op_addr <= cap_addr;
                op_data <= cap_data;
            end
        end
    end

    // outputs
    always_comb begin
        tmr_run          = (state == ST_ERASE_BUSY) || (state == ST_WRITE_BUSY);
        tmr_clr          = !rp_n;
        commit_erase     = rp_n && (state == ST_ERASE_BUSY) && tmr_done;
        commit_write     = rp_n && (state == ST_WRITE_BUSY) && tmr_done;
        status.ready     = !tmr_run;
        status.suspended = (state == ST_ERASE_SUSP) || (state == ST_WRITE_SUSP);
        status.erase_err = erase_err;
        status.write_err = write_err;
    end

    // R11
    pin_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rp_n |=> (state == ST_READY && rmode == RM_ARRAY && !erase_err && !write_err));

    // R6
    erase_seq_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_n && state == ST_ERASE_SETUP && strobe && opcode != OP_CONFIRM)
        |=> (erase_err && write_err && state == ST_READY && rmode == RM_STATUS));

    // R7
    write_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_n && state == ST_WRITE_SETUP && strobe) |=> (state == ST_WRITE_BUSY));

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
    import flash_cmd_pkg::*;
#(
    parameter int              ADDR_W       = 5,
    parameter int              DATA_W       = 16,
    parameter int              BLK_W        = 2,
    parameter int              ERASE_CYCLES = 40,
    parameter int              WRITE_CYCLES = 8,
    parameter logic [DATA_W-1:0] MFR_CODE   = 16'h005A,
    parameter logic [DATA_W-1:0] DEV_CODE   = 16'h00C3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rp_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              oe_we_clash
);
    localparam int WORDS   = 1 << ADDR_W;
    localparam int BLK_LSB = ADDR_W - BLK_W;
    localparam int MAX_CYC = (ERASE_CYCLES > WRITE_CYCLES) ? ERASE_CYCLES : WRITE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic              strobe;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;
    fsm_state_t        state;
    read_mode_t        rmode;
    status_t           status;
    logic              tmr_load, tmr_run, tmr_clr, tmr_done;
    logic [CNT_W-1:0]  tmr_load_val, tmr_count;
    logic              commit_erase, commit_write;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] op_data;
    logic [DATA_W-1:0] mem [WORDS];
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] status_word;

    bus_write_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .rp_n(rp_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .strobe(strobe), .cap_addr(cap_addr),
        .cap_data(cap_data), .clash(oe_we_clash)
    );

    cmd_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W), .CNT_W(CNT_W),
        .ERASE_CYCLES(ERASE_CYCLES), .WRITE_CYCLES(WRITE_CYCLES)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .rp_n(rp_n), .strobe(strobe),
        .cap_addr(cap_addr), .cap_data(cap_data), .tmr_done(tmr_done),
        .state(state), .rmode(rmode), .status(status),
        .tmr_load(tmr_load), .tmr_load_val(tmr_load_val), .tmr_run(tmr_run),
        .tmr_clr(tmr_clr), .commit_erase(commit_erase), .commit_write(commit_write),
        .op_addr(op_addr), .op_data(op_data)
    );

    busy_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .load(tmr_load),
        .load_val(tmr_load_val), .run(tmr_run), .done(tmr_done), .count(tmr_count)
    );

    // storage: erased at power-on, updated on completion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        end else begin
            for (int i = 0; i < WORDS; i++) begin
                if (commit_erase &&
                    ADDR_W'(i) >> BLK_LSB == op_addr >> BLK_LSB) begin
                    mem[i] <= '1;
                end else if (commit_write && op_addr == ADDR_W'(i)) begin
                    mem[i] <= op_data;
                end
            end
        end
    end

    always_comb begin
        status_word    = '0;
        status_word[7] = status.ready;
        status_word[6] = status.suspended;
        status_word[5] = status.erase_err;
        status_word[4] = status.write_err;
    end

    always_comb begin
        unique case (rmode)
            RM_ARRAY:  rd_word = mem[addr];
            RM_IDENT:  rd_word = addr[0] ? DEV_CODE : MFR_CODE;
            RM_STATUS: rd_word = status_word;
            default:   rd_word = '0;
        endcase
    end

    assign dout_en = rp_n && !ce_n && !oe_n && we_n;
    assign dout    = dout_en ? rd_word : '0;

    // R10
    clash_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_we_clash |-> !dout_en);

    // R9
    suspend_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_n && (state == ST_ERASE_SUSP || state == ST_WRITE_SUSP)) |=> $stable(tmr_count));

    // R5
    erase_busy_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_count != '0 && state == ST_ERASE_BUSY) |-> !status.ready);

endmodule

// File: tb/flash_cmd_if_tb.sv
`timescale 1ns/1ps
module flash_cmd_if_tb;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;
    localparam int ERASE_N = 40;
    localparam int WRITE_N = 8;
    localparam logic [15:0] MFR = 16'h005A;
    localparam logic [15:0] DEV = 16'h00C3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rp_n = 1'b1, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] dout;
    logic dout_en, oe_we_clash;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [15:0] model [32];
    logic [15:0] rd;
    logic en;

    always #2 clk = ~clk;

    flash_cmd_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERASE_CYCLES(ERASE_N),
        .WRITE_CYCLES(WRITE_N), .MFR_CODE(MFR), .DEV_CODE(DEV)) u_dut (
        .clk(clk), .rst_n(rst_n), .rp_n(rp_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .oe_we_clash(oe_we_clash)
    );

    function automatic logic [15:0] sr(input bit rdy, input bit sus, input bit ee, input bit we);
        return {8'h00, rdy, sus, ee, we, 4'h0};
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [15:0] d);
        @(negedge clk); addr = a; din = d; ce_n = 0; we_n = 0; oe_n = 1;
        @(negedge clk); ce_n = 1; we_n = 1;
        @(negedge clk);
    endtask

    // read at the current moment, called just after a falling edge
    task automatic peek(input logic [ADDR_W-1:0] a, output logic [15:0] d, output logic e);
        addr = a; ce_n = 0; oe_n = 0; we_n = 1;
        #1; d = dout; e = dout_en;
        ce_n = 1; oe_n = 1;
    endtask

    task automatic rd_check(input string req, input logic [ADDR_W-1:0] a, input logic [15:0] exp);
        logic [15:0] v; logic e;
        @(negedge clk); peek(a, v, e);
        check(req, {15'd0, e}, 16'd1);
        check(req, v, exp);
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 32; i++) model[i] = 16'hFFFF;
        wait_cycles(3);
        rst_n = 1;
        wait_cycles(2);

        // R12 reset state and output enable gating
        @(negedge clk); #1;
        check("R12 idle", {15'd0, dout_en}, 16'd0);
        check("R12 idle data", dout, 16'h0000);
        ce_n = 0; oe_n = 1; #1;
        check("R12 oe high", {15'd0, dout_en}, 16'd0);
        ce_n = 1; oe_n = 0; #1;
        check("R12 ce high", {15'd0, dout_en}, 16'd0);
        oe_n = 1;
        rd_check("R1 erased after reset", 5'd3, 16'hFFFF);

        // R2 identifier mode and R13 unknown commands
        bus_write(5'd0, 16'h0090);
        rd_check("R2 manufacturer", 5'd0, MFR);
        rd_check("R2 device", 5'd1, DEV);
        rd_check("R2 even address", 5'd6, MFR);
        bus_write(5'd0, 16'h0033);
        rd_check("R13 unknown keeps ident", 5'd7, DEV);
        bus_write(5'd0, 16'h00FF);
        rd_check("R1 back to array", 5'd1, 16'hFFFF);

        // R7 word write with busy timing, R3 status layout
        bus_write(5'd5, 16'h0040);
        bus_write(5'd5, 16'h1234);
        peek(5'd0, rd, en);
        check("R7 busy after confirm", rd, sr(0,0,0,0));
        wait_cycles(WRITE_N - 1);
        peek(5'd0, rd, en);
        check("R7 busy last cycle", rd, sr(0,0,0,0));
        wait_cycles(1);
        peek(5'd0, rd, en);
        check("R3 ready status", rd, sr(1,0,0,0));
        model[5] = 16'h1234;
        bus_write(5'd0, 16'h00FF);
        rd_check("R7 word stored", 5'd5, 16'h1234);

        // R8 capture takes last active cycle, chip enable rising first
        bus_write(5'd2, 16'h0010);
        @(negedge clk); addr = 5'd4; din = 16'hDEAD; ce_n = 0; we_n = 0;
        @(negedge clk); addr = 5'd6; din = 16'h4321;
        @(negedge clk); ce_n = 1;
        @(negedge clk); we_n = 1;
        wait_cycles(WRITE_N + 1);
        model[6] = 16'h4321;
        bus_write(5'd0, 16'h00FF);
        rd_check("R8 last address used", 5'd6, 16'h4321);
        rd_check("R8 first address untouched", 5'd4, model[4]);

        // R7 random word writes with either setup code
        for (int k = 0; k < 12; k++) begin
            logic [ADDR_W-1:0] a, b;
            logic [15:0] d;
            a = ADDR_W'($urandom % 32);
            b = ADDR_W'($urandom % 32);
            d = 16'($urandom);
            bus_write(a, ($urandom % 2) ? 16'h0040 : 16'h0010);
            bus_write(a, d);
            wait_cycles(WRITE_N + 1);
            model[a] = d;
            bus_write(b, 16'h00FF);
            rd_check("R7 random target", a, model[a]);
            rd_check("R1 random other", b, model[b]);
        end

        // R5 block erase
        bus_write(5'd8, 16'h0040);  bus_write(5'd8, 16'h1111);  wait_cycles(WRITE_N + 1);
        bus_write(5'd15, 16'h0040); bus_write(5'd15, 16'h2222); wait_cycles(WRITE_N + 1);
        bus_write(5'd16, 16'h0040); bus_write(5'd16, 16'h3333); wait_cycles(WRITE_N + 1);
        model[8] = 16'h1111; model[15] = 16'h2222; model[16] = 16'h3333;
        bus_write(5'd8, 16'h0020);
        bus_write(5'd15, 16'h00D0);
        peek(5'd3, rd, en);
        check("R5 busy in status mode", rd, sr(0,0,0,0));
        wait_cycles(ERASE_N - 1);
        peek(5'd3, rd, en);
        check("R5 busy last cycle", rd, sr(0,0,0,0));
        wait_cycles(1);
        peek(5'd3, rd, en);
        check("R5 ready after erase", rd, sr(1,0,0,0));
        for (int i = 8; i < 16; i++) model[i] = 16'hFFFF;
        bus_write(5'd0, 16'h00FF);
        rd_check("R5 block erased low", 5'd8, 16'hFFFF);
        rd_check("R5 block erased high", 5'd15, 16'hFFFF);
        rd_check("R5 other block kept", 5'd16, 16'h3333);
        rd_check("R5 first block kept", 5'd5, model[5]);

        // R6 sequence errors, R4 clear
        bus_write(5'd16, 16'h0020);
        bus_write(5'd16, 16'h00FF);
        rd_check("R6 bad confirm code", 5'd0, sr(1,0,1,1));
        bus_write(5'd0, 16'h0050);
        rd_check("R4 flags cleared, status mode kept", 5'd0, sr(1,0,0,0));
        bus_write(5'd16, 16'h0020);
        bus_write(5'd24, 16'h00D0);
        rd_check("R6 wrong block", 5'd0, sr(1,0,1,1));
        wait_cycles(ERASE_N + 2);
        bus_write(5'd0, 16'h00FF);
        rd_check("R6 nothing erased", 5'd16, 16'h3333);
        bus_write(5'd0, 16'h0050);

        // R9 suspend and resume of a word write
        bus_write(5'd0, 16'h00FF);
        bus_write(5'd20, 16'h0040);
        bus_write(5'd20, 16'hBEEF);
        wait_cycles(2);
        bus_write(5'd0, 16'h00B0);
        peek(5'd0, rd, en);
        check("R9 suspended status", rd, sr(1,1,0,0));
        bus_write(5'd0, 16'h00FF);
        rd_check("R9 array while suspended", 5'd20, model[20]);
        wait_cycles(20);
        bus_write(5'd0, 16'h0070);
        rd_check("R9 still suspended", 5'd0, sr(1,1,0,0));
        bus_write(5'd0, 16'h00D0);
        peek(5'd0, rd, en);
        check("R9 resumed busy", rd, sr(0,0,0,0));
        wait_cycles(WRITE_N + 1);
        peek(5'd0, rd, en);
        check("R9 completes", rd, sr(1,0,0,0));
        model[20] = 16'hBEEF;
        bus_write(5'd0, 16'h00FF);
        rd_check("R9 word after resume", 5'd20, 16'hBEEF);

        // R9 suspend/resume with nothing running are ignored
        bus_write(5'd0, 16'h00B0);
        rd_check("R9 idle suspend ignored", 5'd3, model[3]);
        bus_write(5'd0, 16'h00D0);
        rd_check("R9 idle resume ignored", 5'd3, model[3]);
        bus_write(5'd0, 16'h0070);
        rd_check("R9 not suspended", 5'd0, sr(1,0,0,0));

        // R10 write overlapping output enable
        bus_write(5'd0, 16'h00FF);
        @(negedge clk); addr = 5'd1; din = 16'h0090; ce_n = 0; we_n = 0; oe_n = 0;
        #1;
        check("R10 clash flag", {15'd0, oe_we_clash}, 16'd1);
        check("R10 no drive", {15'd0, dout_en}, 16'd0);
        @(negedge clk); ce_n = 1; we_n = 1; oe_n = 1;
        #1;
        check("R10 clash clears", {15'd0, oe_we_clash}, 16'd0);
        rd_check("R10 write discarded", 5'd1, model[1]);

        // R11 power-down during erase
        bus_write(5'd9, 16'h0040); bus_write(5'd9, 16'hA5A5); wait_cycles(WRITE_N + 1);
        model[9] = 16'hA5A5;
        bus_write(5'd8, 16'h0020);
        bus_write(5'd8, 16'h0011);
        rd_check("R6 error before power-down", 5'd0, sr(1,0,1,1));
        bus_write(5'd8, 16'h0020);
        bus_write(5'd9, 16'h00D0);
        wait_cycles(5);
        @(negedge clk); rp_n = 0;
        peek(5'd9, rd, en);
        check("R11 outputs off", {15'd0, en}, 16'd0);
        check("R11 data zero", rd, 16'h0000);
        bus_write(5'd0, 16'h0090);
        @(negedge clk); rp_n = 1;
        rd_check("R11 array mode, not erased", 5'd9, 16'hA5A5);
        bus_write(5'd0, 16'h0070);
        rd_check("R11 flags cleared, idle", 5'd0, sr(1,0,0,0));
        wait_cycles(ERASE_N + 2);
        bus_write(5'd0, 16'h00FF);
        rd_check("R11 abort persists", 5'd9, 16'hA5A5);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule